// File: doc/BRIEF.md
# Timestamped Pattern Input Capture

This block watches a group of sixteen logic inputs and turns activity on them into pattern events. Each event carries a 16-bit pattern and the 48-bit timestamp taken from an external free-running counter (100 MHz time base). Every input first has its polarity chosen by a per-bit invert mask and is then gated by a per-bit enable mask. After that, only rising edges count.

A runtime mode selects how events are formed:
- **Single-input:** edge detection on every clock, optionally qualified by the group gate.
- **Gated-group:** hits are collected while a gate window is open. The timestamp is taken when the gate opens and the event is emitted when it closes.
- **Coincidence:** a bit counts when input bit n and a second group's bit n are both true.
- **Off:** produces nothing.

In any mode, the primary group can have its pulses lengthened in 50 ns steps.

Events leave on a valid/ready handshake. An event that arrives while a previous one is still waiting is discarded, and this sets a sticky overflow flag.

Top module: `tspat_capture`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0.
- R2: Each pin passes through its invert bit (XOR) and then its enable bit (AND). A disabled bit never appears in a pattern. An inverted bit fires on the falling edge of its pin.
- R3: In mode 0 (single-input), a conditioned bit that goes from 0 to 1 produces an event. The pattern holds exactly the bits that rose, and the timestamp is `ts_now` sampled with that event. A change on the pins appears at `out_valid` two clocks later. Bits that stay high produce no further events.
- R4: In mode 0 with `cfg_gate_and` set, a bit counts only while `gate_in` is high. The choice applies to all sixteen bits.
- R5: In mode 1 (gated-group), the timestamp is latched when the gate opens, and every conditioned bit seen high while the gate is open is ORed into the pattern. The event is emitted two clocks after `gate_in` falls.
- R6: In mode 1, a gate window that closes with an all-zero pattern produces no event.
- R7: When `cfg_stretch_en` is 1 and `cfg_stretch_len` is nonzero, each conditioned bit of group A stays high for `cfg_stretch_len`×5 extra cycles after it drops. A new pulse inside that stretch produces no new event. A length of 0 disables stretching.
- R8: In mode 2 (coincidence), an event occurs when any bit of (A AND B) becomes true, and the pattern is the full current A AND B vector. Group B passes through `cfg_b_enable` only and is never inverted.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pattern` and `out_ts` hold steady.
- R10: An event that arrives while `out_valid` is high and `out_ready` is low is dropped. It sets `overflow`, which stays set until reset.
- R11: Mode 3 produces no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_a_in | input | 16 | Primary input group |
| grp_b_in | input | 16 | Second group used in coincidence mode |
| gate_in | input | 1 | Group gate |
| ts_now | input | 48 | Current value of the external timestamp counter |
| cfg_enable | input | 16 | Per-bit enable for group A |
| cfg_invert | input | 16 | Per-bit invert for group A |
| cfg_b_enable | input | 16 | Per-bit enable for group B |
| cfg_mode | input | 2 | 0 single, 1 gated, 2 coincidence, 3 off |
| cfg_gate_and | input | 1 | Qualify single-input mode with the gate |
| cfg_stretch_en | input | 1 | Pulse stretching on |
| cfg_stretch_len | input | 4 | Stretch length in 5-cycle steps |
| out_valid | output | 1 | Event available |
| out_ready | input | 1 | Consumer accepts the event |
| out_pattern | output | 16 | Event pattern |
| out_ts | output | 48 | Event timestamp |
| overflow | output | 1 | Sticky event-dropped flag |

## Verification
On every cycle, the assertions check the following:
- the output handshake holds steady while stalled;
- the overflow flag is sticky, and a stalled event always raises it;
- no emitted or internal event ever carries an empty pattern;
- the off mode never fires.

Only the bench scenarios can show the mode-dependent pattern contents, the two-clock latency, gate-open timestamp latching, the stretch window length and the masking and inversion. Each of these needs an expected value built from a stimulus history.

// File: rtl/tspat_pkg.sv
package tspat_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_GATED  = 2'd1,
    MODE_COINC  = 2'd2,
    MODE_OFF    = 2'd3
  } mode_e;

  // Number of cycles a stretch setting adds after the input drops.
  function automatic int unsigned stretch_cycles(input int unsigned len,
                                                 input int unsigned step);
    return len * step;
  endfunction

  // Width needed to hold the longest stretch.
  function automatic int unsigned stretch_cnt_width(input int unsigned len_w,
                                                    input int unsigned step);
    return $clog2(((1 << len_w) - 1) * step + 1);
  endfunction

endpackage

// File: rtl/tspat_condition.sv
module tspat_condition #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] enable,
  input  logic [W-1:0] invert,
  output logic [W-1:0] cond_q
);

  // Polarity first, then mask; one register stage.
  function automatic logic [W-1:0] condition(input logic [W-1:0] p,
                                             input logic [W-1:0] inv,
                                             input logic [W-1:0] en);
    return (p ^ inv) & en;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= condition(pins, invert, enable);
  end

endmodule

// File: rtl/tspat_stretch.sv
module tspat_stretch
  import tspat_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = 4,
  parameter int STEP  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     lvl_in,
  input  logic             stretch_en,
  input  logic [LEN_W-1:0] stretch_len,
  output logic [W-1:0]     lvl_out
);

  localparam int CNT_W = stretch_cnt_width(LEN_W, STEP);

  logic             active;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    active   = stretch_en && (stretch_len != '0);
    load_val = CNT_W'(stretch_cycles(int'(stretch_len), STEP));
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n || !active) cnt_q <= '0;
      else if (lvl_in[i])    cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign lvl_out[i] = lvl_in[i] | (active & (cnt_q != '0));
  end

endmodule

// File: rtl/tspat_detect.sv
module tspat_detect
  import tspat_pkg::*;
#(
  parameter int W    = 16,
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mode_e           mode,
  input  logic            gate_and,
  input  logic [W-1:0]    lvl_a,
  input  logic [W-1:0]    lvl_b,
  input  logic            gate_lvl,
  input  logic [TS_W-1:0] ts_now,
  output logic            ev_fire,
  output logic [W-1:0]    ev_pattern,
  output logic [TS_W-1:0] ev_ts
);

  logic [W-1:0]    sel_lvl;
  logic [W-1:0]    prev_q;
  logic [W-1:0]    rise;
  logic            gprev_q;
  logic [W-1:0]    acc_q;
  logic [TS_W-1:0] gts_q;
  logic            gate_open;
  logic            gate_close;

  always_comb begin
    unique case (mode)
      MODE_SINGLE: sel_lvl = lvl_a & (gate_and ? {W{gate_lvl}} : {W{1'b1}});
      MODE_COINC:  sel_lvl = lvl_a & lvl_b;
      default:     sel_lvl = '0;
    endcase
    rise       = sel_lvl & ~prev_q;
    gate_open  = gate_lvl & ~gprev_q;
    gate_close = ~gate_lvl & gprev_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      gprev_q <= 1'b0;
      acc_q   <= '0;
      gts_q   <= '0;
    end else begin
      prev_q  <= sel_lvl;
      gprev_q <= gate_lvl;
      if (gate_open) begin
        acc_q <= lvl_a;
        gts_q <= ts_now;
      end else if (gate_lvl) begin
        acc_q <= acc_q | lvl_a;
      end
    end
  end

  always_comb begin
    ev_fire    = 1'b0;
    ev_pattern = '0;
    ev_ts      = ts_now;
    unique case (mode)
      MODE_SINGLE: begin
        ev_fire    = |rise;
        ev_pattern = rise;
      end
      MODE_COINC: begin
        ev_fire    = |rise;
        ev_pattern = sel_lvl;
      end
      MODE_GATED: begin
        ev_fire    = gate_close && (acc_q != '0);
        ev_pattern = acc_q;
        ev_ts      = gts_q;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tspat_outreg.sv
module tspat_outreg #(
  parameter int W    = 16,
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_fire,
  input  logic [W-1:0]    ev_pattern,
  input  logic [TS_W-1:0] ev_ts,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [W-1:0]    out_pattern,
  output logic [TS_W-1:0] out_ts,
  output logic            overflow,
  output logic            ev_drop
);

  logic take;

  always_comb begin
    take    = ev_fire && (!out_valid || out_ready);
    ev_drop = ev_fire && out_valid && !out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pattern <= '0;
      out_ts      <= '0;
      overflow    <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_pattern <= ev_pattern;
        out_ts      <= ev_ts;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (ev_drop) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/tspat_capture.sv
module tspat_capture
  import tspat_pkg::*;
#(
  parameter int W     = 16,
  parameter int TS_W  = 48,
  parameter int LEN_W = 4,
  parameter int STEP  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     grp_a_in,
  input  logic [W-1:0]     grp_b_in,
  input  logic             gate_in,
  input  logic [TS_W-1:0]  ts_now,
  input  logic [W-1:0]     cfg_enable,
  input  logic [W-1:0]     cfg_invert,
  input  logic [W-1:0]     cfg_b_enable,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_gate_and,
  input  logic             cfg_stretch_en,
  input  logic [LEN_W-1:0] cfg_stretch_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_pattern,
  output logic [TS_W-1:0]  out_ts,
  output logic             overflow
);

  logic [W-1:0]    cond_a;
  logic [W-1:0]    cond_b;
  logic [0:0]      cond_gate;
  logic [W-1:0]    lvl_a;
  logic            ev_fire;
  logic [W-1:0]    ev_pattern;
  logic [TS_W-1:0] ev_ts;
  logic            ev_drop;

  tspat_condition #(.W(W)) cond_a_i (
    .clk(clk), .rst_n(rst_n), .pins(grp_a_in),
    .enable(cfg_enable), .invert(cfg_invert), .cond_q(cond_a)
  );

  tspat_condition #(.W(W)) cond_b_i (
    .clk(clk), .rst_n(rst_n), .pins(grp_b_in),
    .enable(cfg_b_enable), .invert({W{1'b0}}), .cond_q(cond_b)
  );

  tspat_condition #(.W(1)) cond_gate_i (
    .clk(clk), .rst_n(rst_n), .pins(gate_in),
    .enable(1'b1), .invert(1'b0), .cond_q(cond_gate)
  );

  tspat_stretch #(.W(W), .LEN_W(LEN_W), .STEP(STEP)) stretch_i (
    .clk(clk), .rst_n(rst_n), .lvl_in(cond_a),
    .stretch_en(cfg_stretch_en), .stretch_len(cfg_stretch_len),
    .lvl_out(lvl_a)
  );

  tspat_detect #(.W(W), .TS_W(TS_W)) detect_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_e'(cfg_mode)),
    .gate_and(cfg_gate_and), .lvl_a(lvl_a), .lvl_b(cond_b),
    .gate_lvl(cond_gate[0]), .ts_now(ts_now),
    .ev_fire(ev_fire), .ev_pattern(ev_pattern), .ev_ts(ev_ts)
  );

  tspat_outreg #(.W(W), .TS_W(TS_W)) outreg_i (
    .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire),
    .ev_pattern(ev_pattern), .ev_ts(ev_ts), .out_ready(out_ready),
    .out_valid(out_valid), .out_pattern(out_pattern), .out_ts(out_ts),
    .overflow(overflow), .ev_drop(ev_drop)
  );

endmodule

// File: rtl/tspat_capture_chk.sv
module tspat_capture_chk #(
  parameter int W    = 16,
  parameter int TS_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_mode,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_pattern,
  input logic [TS_W-1:0] out_ts,
  input logic            overflow,
  input logic            ev_fire,
  input logic [W-1:0]    ev_pattern,
  input logic            ev_drop
);

  // R9: a stalled output holds its contents.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pattern) && $stable(out_ts)));

  // R10: overflow is sticky.
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R10: a dropped event always raises overflow.
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> overflow);

  // R3: an emitted event always carries at least one bit.
  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pattern != '0));

  // R6: no internal event carries an empty pattern.
  p_gate_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |-> (ev_pattern != '0));

  // R11: off mode never fires.
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd3) |-> !ev_fire);

endmodule

bind tspat_capture tspat_capture_chk #(.W(W), .TS_W(TS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .out_valid(out_valid),
  .out_ready(out_ready), .out_pattern(out_pattern), .out_ts(out_ts),
  .overflow(overflow), .ev_fire(ev_fire), .ev_pattern(ev_pattern),
  .ev_drop(ev_drop)
);

// File: tb/tspat_capture_tb_top.sv
module tspat_capture_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] grp_a_in, grp_b_in, cfg_enable, cfg_invert, cfg_b_enable;
  logic        gate_in, cfg_gate_and, cfg_stretch_en, out_ready;
  logic [47:0] ts_now;
  logic [1:0]  cfg_mode;
  logic [3:0]  cfg_stretch_len;
  logic        out_valid, overflow;
  logic [15:0] out_pattern;
  logic [47:0] out_ts;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tspat_capture dut_i (
    .clk(clk), .rst_n(rst_n), .grp_a_in(grp_a_in), .grp_b_in(grp_b_in),
    .gate_in(gate_in), .ts_now(ts_now), .cfg_enable(cfg_enable),
    .cfg_invert(cfg_invert), .cfg_b_enable(cfg_b_enable),
    .cfg_mode(cfg_mode), .cfg_gate_and(cfg_gate_and),
    .cfg_stretch_en(cfg_stretch_en), .cfg_stretch_len(cfg_stretch_len),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pattern(out_pattern), .out_ts(out_ts), .overflow(overflow)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        gand;
    logic        gate;
    logic [15:0] en;
    logic [15:0] inv;
    logic [15:0] bef;
    logic [15:0] aft;
    logic [15:0] b;
    logic        ev;
    logic [15:0] pat;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0005, 16'h0000, 1'b1, 16'h0005}, // R3 new bits
    '{2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0005, 16'h0007, 16'h0000, 1'b1, 16'h0002}, // R3 only the riser
    '{2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h00FF, 16'h00FF, 16'h0000, 1'b0, 16'h0000}, // R3 held level
    '{2'd0, 1'b0, 1'b0, 16'h00F0, 16'h0000, 16'h0000, 16'h00FF, 16'h0000, 1'b1, 16'h00F0}, // R2 mask
    '{2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'hFFFF, 16'hFFFE, 16'h0000, 1'b1, 16'h0001}, // R2 invert
    '{2'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h000F, 16'h0000, 1'b0, 16'h0000}, // R4 gate low
    '{2'd0, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 16'h000F, 16'h0000, 1'b1, 16'h000F}, // R4 gate high
    '{2'd2, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h00FF, 16'h00F0, 1'b1, 16'h00F0}, // R8 coincidence
    '{2'd2, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 16'h0000}, // R8 no partner
    '{2'd3, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 16'h0000}  // R11 off
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    grp_a_in = '0; grp_b_in = '0; gate_in = 1'b0; ts_now = '0;
    cfg_enable = 16'hFFFF; cfg_invert = '0; cfg_b_enable = 16'hFFFF;
    cfg_mode = 2'd0; cfg_gate_and = 1'b0; cfg_stretch_en = 1'b0;
    cfg_stretch_len = '0; out_ready = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 overflow", 64'(overflow), 64'd0);

    // Table walk: R2 R3 R4 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      cfg_mode = v.mode; cfg_gate_and = v.gand; gate_in = v.gate;
      cfg_enable = v.en; cfg_invert = v.inv; grp_b_in = v.b;
      grp_a_in = v.bef;
      tick(); tick(); tick(); tick();
      grp_a_in = v.aft;
      ts_now = 48'h1000 + 48'(i);
      tick(); tick();
      check($sformatf("vector %0d valid", i), 64'(out_valid), 64'(v.ev));
      if (v.ev) begin
        check($sformatf("vector %0d pattern", i), 64'(out_pattern), 64'(v.pat));
        check($sformatf("vector %0d timestamp", i), 64'(out_ts), 64'h1000 + 64'(i));
      end
    end

    // R5: gated-group collection
    cfg_mode = 2'd1; cfg_gate_and = 1'b0; cfg_enable = 16'hFFFF; cfg_invert = '0;
    grp_a_in = '0; gate_in = 1'b0;
    tick(); tick(); tick();
    gate_in = 1'b1; grp_a_in = 16'h0001; ts_now = 48'hAAAA;
    tick(); tick();
    grp_a_in = 16'h0100; ts_now = 48'hBBBB;
    tick();
    grp_a_in = 16'h0000;
    tick(); tick();
    check("R5 no event while gate open", 64'(out_valid), 64'd0);
    gate_in = 1'b0;
    tick();
    check("R5 not before two clocks", 64'(out_valid), 64'd0);
    tick();
    check("R5 valid at close", 64'(out_valid), 64'd1);
    check("R5 pattern", 64'(out_pattern), 64'h0101);
    check("R5 timestamp at gate open", 64'(out_ts), 64'hAAAA);

    // R6: empty gate window
    tick(); tick();
    gate_in = 1'b1;
    tick(); tick(); tick();
    gate_in = 1'b0;
    tick(); tick();
    check("R6 empty window no event", 64'(out_valid), 64'd0);
    tick();
    check("R6 empty window still none", 64'(out_valid), 64'd0);

    // R7: stretch length 0 leaves pulses separate
    cfg_mode = 2'd0; cfg_stretch_en = 1'b1; cfg_stretch_len = 4'd0;
    grp_a_in = '0;
    tick(); tick(); tick();
    grp_a_in = 16'h0001; tick();
    grp_a_in = 16'h0000; tick();
    check("R7 len0 first pulse", 64'(out_valid), 64'd1);
    grp_a_in = 16'h0001; tick();
    grp_a_in = 16'h0000; tick();
    check("R7 len0 second pulse", 64'(out_valid), 64'd1);

    // R7: stretch length 1 merges the second pulse
    cfg_stretch_len = 4'd1;
    tick(); tick(); tick(); tick(); tick(); tick(); tick(); tick();
    grp_a_in = 16'h0001; tick();
    grp_a_in = 16'h0000; tick();
    check("R7 len1 first pulse", 64'(out_valid), 64'd1);
    grp_a_in = 16'h0001; tick();
    grp_a_in = 16'h0000; tick();
    check("R7 len1 second pulse merged", 64'(out_valid), 64'd0);
    for (int k = 0; k < 12; k++) tick();
    grp_a_in = 16'h0001; tick();
    grp_a_in = 16'h0000; tick();
    check("R7 pulse after stretch ends", 64'(out_valid), 64'd1);
    cfg_stretch_en = 1'b0; cfg_stretch_len = '0;

    // R9 / R10: stall, hold, drop and sticky overflow
    tick(); tick(); tick();
    out_ready = 1'b0; grp_a_in = 16'h0001; ts_now = 48'h5555;
    tick(); tick();
    check("R9 stalled event valid", 64'(out_valid), 64'd1);
    check("R10 no overflow yet", 64'(overflow), 64'd0);
    grp_a_in = 16'h0003; ts_now = 48'h6666;
    tick(); tick();
    check("R9 pattern held", 64'(out_pattern), 64'h0001);
    check("R9 timestamp held", 64'(out_ts), 64'h5555);
    check("R10 overflow set", 64'(overflow), 64'd1);
    out_ready = 1'b1;
    tick();
    check("R9 released", 64'(out_valid), 64'd0);
    check("R10 overflow sticky", 64'(overflow), 64'd1);
    do_reset();
    check("R10 overflow cleared by reset", 64'(overflow), 64'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule